// File: doc/BRIEF.md
# Vertical Sync and Field Parity Detector

This block watches a clean, active-low composite sync bit and separates vertical timing from it. A width counter runs while sync is low. Short line-rate pulses clear it before it reaches its limit. Broad pulses in the vertical interval let it reach that limit, and the block then arms. The vertical output starts when sync first returns high after arming, which is the first serration edge. If sync stays low too long, a fallback counter starts the vertical output anyway. Once started, the output times itself out.

Every rising sync edge also fires a back-porch gate of fixed width. A line-phase flywheel locks to the line-rate falling edges. It decides field parity at each vertical start. A status flag reports a sync level held low far longer than any valid pulse, which is a sign that video has been lost.

One input, `rate`, gives the number of clock cycles in one time quantum. Every duration is a fixed number of quanta times `rate`, so a single value retunes the whole block to a new scan rate. At the defaults, a line is 64 quanta.

Top module: `vsync_field_det`

## Requirements
- R1: Every duration is a count of quanta times `rate` clock cycles (`rate` ≥ 1). The quanta counts are: line 64, half line 32, width limit 16, fallback 32, vertical width 192, back porch 4, loss 256.
- R2: A low pulse that lasts at most 16·rate clock edges never starts a vertical output.
- R3: A low pulse seen low on 16·rate+1 or more edges arms the block. The vertical output then goes high after the first clock edge that sees `csync_n` high again. It is still low after the last low edge.
- R4: If sync stays low after arming, `vsync` goes high after clock edge number 48·rate+2 of the low pulse. It is low after edge 48·rate+1.
- R5: `vsync` stays high for exactly 192·rate cycles. Broad pulses arriving while it is high neither arm nor extend it.
- R6: Each rising edge of `csync_n` drives `bp_gate` high for exactly 4·rate cycles, starting after the edge that sees the high level.
- R7: A line-phase counter wraps every 64·rate cycles. A falling sync edge, outside arming and outside vertical output, resets it to zero in two cases: the counter stands in its second half, or no reset has happened since reset. At each vertical start, `odd_field` is loaded with 1 if the phase is below 32·rate and with 0 otherwise. It changes at no other time.
- R8: `sync_lost` is high once sync has been low on at least 256·rate edges. It clears after the first edge that sees sync high.
- R9: While reset is asserted and until the first stimulus, `vsync`, `bp_gate`, `odd_field` and `sync_lost` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csync_n | input | 1 | Composite sync, low during sync pulses |
| rate | input | RATE_W | Clock cycles per time quantum |
| vsync | output | 1 | Vertical sync pulse |
| bp_gate | output | 1 | Back-porch gate after each sync pulse |
| odd_field | output | 1 | High during the odd field |
| sync_lost | output | 1 | Sync held low beyond the loss limit |

## Verification
The bench sweeps pulse widths one edge either side of the arming limit at three rates. An off-by-one comparator would make a 16·rate pulse start a vertical or would miss a 16·rate+1 pulse. A held-low pulse pins the fallback start, the vertical end and the loss flag to single cycles. A miscounted fallback or loss threshold, or a flag that failed to clear, would show up there. Three fields alternate between line-aligned and half-line-offset vertical intervals. A flywheel that resynchronised on half-line edges would give the wrong parity on the offset field. A design that re-armed on later broad pulses would give a vertical width other than 192 cycles.

// File: rtl/vsync_field_det.sv
module vsync_field_det #(
  parameter int RATE_W = 8,
  parameter int CNT_W  = 17,
  parameter int LINE_Q = 64,
  parameter int TOUT_Q = 16,
  parameter int FB_Q   = 32,
  parameter int VW_Q   = 192,
  parameter int BP_Q   = 4,
  parameter int LOSS_Q = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csync_n,
  input  logic [RATE_W-1:0] rate,
  output logic              vsync,
  output logic              bp_gate,
  output logic              odd_field,
  output logic              sync_lost
);
  localparam int HALF_Q = LINE_Q / 2;

  logic [CNT_W-1:0] r_ext, line_lim, half_lim, tout_lim, fb_lim, vw_lim, bp_lim, loss_lim;
  assign r_ext    = CNT_W'(rate);
  assign line_lim = CNT_W'(LINE_Q) * r_ext;
  assign half_lim = CNT_W'(HALF_Q) * r_ext;
  assign tout_lim = CNT_W'(TOUT_Q) * r_ext;
  assign fb_lim   = CNT_W'(FB_Q) * r_ext;
  assign vw_lim   = CNT_W'(VW_Q) * r_ext;
  assign bp_lim   = CNT_W'(BP_Q) * r_ext;
  assign loss_lim = CNT_W'(LOSS_Q) * r_ext;

  logic             cs_d, armed, locked;
  logic [CNT_W-1:0] lowcnt, fbcnt, vcnt, bcnt, phase;
  logic             rise, fall, arm_ev, start, resync;

  assign rise   = csync_n & ~cs_d;
  assign fall   = ~csync_n & cs_d;
  assign vsync  = (vcnt != '0);
  assign bp_gate = (bcnt != '0);
  assign sync_lost = (lowcnt >= loss_lim);
  assign arm_ev = ~csync_n && (lowcnt == tout_lim) && !armed && !vsync;
  assign start  = armed && (rise || fbcnt == fb_lim);
  assign resync = fall && !armed && !vsync && (!locked || phase >= half_lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_d      <= 1'b1;
      lowcnt    <= '0;
      armed     <= 1'b0;
      fbcnt     <= '0;
      vcnt      <= '0;
      bcnt      <= '0;
      phase     <= '0;
      locked    <= 1'b0;
      odd_field <= 1'b0;
    end else begin
      cs_d <= csync_n;

      if (csync_n)              lowcnt <= '0;
      else if (lowcnt != '1)    lowcnt <= lowcnt + 1'b1;

      if (start)                armed <= 1'b0;
      else if (arm_ev)          armed <= 1'b1;

      fbcnt <= armed ? fbcnt + 1'b1 : '0;

      if (start)                vcnt <= vw_lim;
      else if (vsync)           vcnt <= vcnt - 1'b1;

      if (rise)                 bcnt <= bp_lim;
      else if (bp_gate)         bcnt <= bcnt - 1'b1;

      if (resync) begin
        phase  <= '0;
        locked <= 1'b1;
      end else if (phase >= line_lim - 1'b1) begin
        phase <= '0;
      end else begin
        phase <= phase + 1'b1;
      end

      if (start)                odd_field <= (phase < half_lim);
    end
  end
endmodule

module vsync_field_det_chk (
  input logic clk,
  input logic rst_n,
  input logic csync_n,
  input logic vsync,
  input logic bp_gate,
  input logic odd_field,
  input logic sync_lost,
  input logic armed,
  input logic rise
);
  assert_bp_after_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> bp_gate);
  assert_lost_while_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> !$past(csync_n));
  assert_parity_at_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(odd_field) |-> $rose(vsync));
  assert_start_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> $past(armed));
  assert_no_arm_in_vsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> !armed);
endmodule

bind vsync_field_det vsync_field_det_chk u_chk (.*);

// File: tb/vsync_field_det_tb.sv
module vsync_field_det_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csync_n = 1'b1;
  logic [7:0] rate = 8'd1;
  logic       vsync, bp_gate, odd_field, sync_lost;
  int         checks = 0, errors = 0, vacc = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  vsync_field_det u_dut (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .rate(rate),
    .vsync(vsync), .bp_gate(bp_gate), .odd_field(odd_field), .sync_lost(sync_lost)
  );

  // {rate, low edges, vertical expected}
  localparam int TBL [0:7][0:2] = '{
    '{2, 20, 0}, '{2, 32, 0}, '{2, 33, 1}, '{1, 16, 0},
    '{1, 17, 1}, '{3, 48, 0}, '{3, 49, 1}, '{2, 60, 1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic seg(input logic v, input int n);
    csync_n = v;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vacc += vsync;
    end
  endtask

  task automatic hlines(input int n);
    for (int i = 0; i < n; i++) begin
      seg(0, 5);
      seg(1, 59);
    end
  endtask

  task automatic field(input bit offset, input int exp_odd);
    vacc = 0;
    if (offset) seg(1, 32);
    seg(0, 27);
    chk("R3 vsync before serration", vsync, 0);
    seg(1, 1);
    chk("R3 vsync at serration", vsync, 1);
    chk("R7 parity", odd_field, exp_odd);
    seg(1, 4);
    for (int b = 0; b < 5; b++) begin
      seg(0, 27);
      seg(1, 5);
    end
    if (offset) seg(1, 32);
    hlines(6);
    chk("R5 vsync width in field", vacc, 192);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 vsync in reset", vsync, 0);
    chk("R9 bp_gate in reset", bp_gate, 0);
    chk("R9 odd_field in reset", odd_field, 0);
    chk("R9 sync_lost in reset", sync_lost, 0);
    rst_n = 1'b1;

    for (int e = 0; e < 8; e++) begin
      int vc, bc;
      rate = 8'(TBL[e][0]);
      seg(1, 20);
      seg(0, TBL[e][1]);
      vc = 0;
      bc = 0;
      csync_n = 1'b1;
      for (int i = 0; i < 800; i++) begin
        @(negedge clk);
        vc += vsync;
        bc += bp_gate;
      end
      chk(TBL[e][2] ? "R3 R1 vertical width" : "R2 short pulse no vertical",
          vc, TBL[e][2] ? 192 * TBL[e][0] : 0);
      chk("R6 R1 back porch width", bc, 4 * TBL[e][0]);
    end

    rate = 8'd2;
    seg(1, 50);
    seg(0, 97);
    chk("R4 no vsync before fallback", vsync, 0);
    seg(0, 1);
    chk("R4 fallback start", vsync, 1);
    seg(0, 383);
    chk("R5 vsync last cycle", vsync, 1);
    seg(0, 1);
    chk("R5 vsync ended", vsync, 0);
    seg(0, 29);
    chk("R8 lost below limit", sync_lost, 0);
    seg(0, 1);
    chk("R8 lost at limit", sync_lost, 1);
    seg(1, 1);
    chk("R8 lost cleared", sync_lost, 0);
    chk("R3 no restart without arming", vsync, 0);
    seg(1, 7);
    chk("R6 bp last cycle", bp_gate, 1);
    seg(1, 1);
    chk("R6 bp ended", bp_gate, 0);

    rate = 8'd1;
    seg(1, 100);
    hlines(4);
    field(1'b0, 1);
    field(1'b1, 0);
    field(1'b0, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule